// File: doc/BRIEF.md
# Capability load revocation filter

This block sits on the return path of a capability load. A loaded word is 33 bits wide, and its top bit is the valid tag that marks it as a capability. The block takes that word together with the capability's base address, which an external bounds decoder supplies. From the base it computes where the matching revocation bit lives in a shadow bitmap. It reads that 32-bit word over its own request/response port and hands the capability back. If the bit marks the 8-byte heap granule under the base as revoked, the tag is cleared.

Only capabilities whose base falls in the heap are looked up. The heap starts at `HEAP_BASE` and spans `SMAP_WORDS × 32 × 8` bytes. A lookup also needs the filter enable high, an incoming tag of 1, and a computed shadow word address no higher than `SMAP_TOP`. Every other load finishes in the cycle after it is accepted, with no shadow read. While a load is in progress the block reports busy, and any new load offered in that time is dropped.

Top module: `cap_revoke_filter`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `smap_req_o` and `res_valid_o` are all 0.
- R2: If a lookup is made and the selected shadow bit is 1, the result has bit 32 (the tag) cleared.
- R3: If a lookup is made and the selected shadow bit is 0, the tag is returned as 1. Bits 31:0 of the result always equal bits 31:0 of the accepted load word.
- R4: When `filt_en_i` is 0 at acceptance, no shadow request is issued and the word is returned unchanged.
- R5: A base below `HEAP_BASE`, or at or above `HEAP_BASE + SMAP_WORDS*256`, issues no request and the word is returned unchanged.
- R6: For an in-heap base, let off = base − `HEAP_BASE`. The request address is `SMAP_BASE + 4*(off>>8)`, and the selected bit of the response word is off[7:3]. Bit index 31 is the top bit of a word, and bit index 32 is bit 0 of the next word.
- R7: If the computed word address exceeds `SMAP_TOP`, no request is issued and the word is returned unchanged.
- R8: A word accepted with its tag at 0 issues no request. Its result is valid in the cycle after acceptance, with the tag still 0.
- R9: For a lookup, `smap_req_o` is high for exactly the one cycle after acceptance. `busy_o` stays high from that cycle until the result cycle, inclusive. `res_valid_o` is high for exactly one cycle, one cycle after the response is taken.
- R10: A load offered while `busy_o` is high is ignored. A shadow response that arrives while no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid_i | input | 1 | A load word is offered this cycle |
| ld_data_i | input | 33 | Loaded word, bit 32 is the capability tag |
| cap_base_i | input | 32 | Decoded base address of the loaded capability |
| filt_en_i | input | 1 | Enables the revocation lookup |
| busy_o | output | 1 | A load is being processed |
| smap_req_o | output | 1 | Shadow word read request |
| smap_addr_o | output | 32 | Byte address of the shadow word |
| smap_rsp_valid_i | input | 1 | Shadow read data is valid |
| smap_rsp_data_i | input | 32 | Shadow word read data |
| res_valid_o | output | 1 | Result strobe, one cycle |
| res_data_o | output | 33 | Returned word with the possibly cleared tag |

## Verification
The assertions assume that the shadow memory sends one response per request, and never in the same cycle as the request. They also assume that `cap_base_i` and `filt_en_i` are meaningful in the cycle `ld_valid_i` is high. The stimulus offers loads only at negative edges. It waits for each result before starting the next load, except in one case that deliberately offers a load while busy. The behavioural memory answers only after it has seen a request, with latencies of one to three cycles. One stray response is injected while the block is idle, and the stimulus checks that it has no effect.

// File: rtl/revf_pkg.sv
// Package: shared state type for the capability revocation filter.
// Assumes: nothing beyond a 2-bit state encoding.
package revf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } revf_state_e;
endpackage

// File: rtl/revf_addr_calc.sv
// Module: maps a capability base to its shadow word address and bit select,
// and qualifies whether a lookup is possible (base in heap, word within top).
// Assumes: HEAP_SPAN fits in ADDR_W bits; purely combinational.
module revf_addr_calc #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] HEAP_BASE  = 32'h8000_0000,
    parameter int          SMAP_WORDS = 1024,
    parameter logic [31:0] SMAP_BASE  = 32'h4000_0000,
    parameter logic [31:0] SMAP_TOP   = 32'h4000_0FFC
) (
    input  logic [ADDR_W-1:0] base_i,
    output logic              qualify_o,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic [4:0]        bit_sel_o
);
    // 32 bits per word, 8 bytes per bit: 256 heap bytes per shadow word
    localparam logic [ADDR_W:0] HEAP_SPAN = (ADDR_W+1)'(SMAP_WORDS) << 8;

    logic [ADDR_W-1:0] off;
    logic              in_heap;

    // Offset, heap qualification, address and bit select
    always_comb begin
        off         = base_i - ADDR_W'(HEAP_BASE);
        in_heap     = (base_i >= ADDR_W'(HEAP_BASE)) && ({1'b0, off} < HEAP_SPAN);
        word_addr_o = ADDR_W'(SMAP_BASE) + ((off >> 8) << 2);
        bit_sel_o   = off[7:3];
        qualify_o   = in_heap && (word_addr_o <= ADDR_W'(SMAP_TOP));
    end
endmodule

// File: rtl/revf_bit_pick.sv
// Module: selects one revocation bit from a shadow word.
// Assumes: WORD_W is a power of two matching the select width.
module revf_bit_pick #(
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              bit_o
);
    // Indexed bit selection
    always_comb bit_o = word_i[sel_i];
endmodule

// File: rtl/revf_ctrl.sv
// Module: sequencer for one load at a time: idle, shadow request, wait for
// response, result. Loads not needing a lookup go straight to the result.
// Assumes: at most one response per request; responses outside WAIT ignored.
module revf_ctrl
    import revf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic need_lookup_i,
    input  logic rsp_valid_i,
    output logic idle_o,
    output logic req_o,
    output logic capture_o,
    output logic done_o
);
    revf_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept_i) state_d = need_lookup_i ? ST_REQ : ST_DONE;
            ST_REQ:  state_d = ST_WAIT;
            ST_WAIT: if (rsp_valid_i) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded outputs
    always_comb begin
        idle_o    = (state_q == ST_IDLE);
        req_o     = (state_q == ST_REQ);
        capture_o = (state_q == ST_WAIT) && rsp_valid_i;
        done_o    = (state_q == ST_DONE);
    end

    a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o && !done_o);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> idle_o);
endmodule

// File: rtl/cap_revoke_filter.sv
// Module: top of the capability load revocation filter. Holds the accepted
// word, reads one shadow word when the base is in the heap, and clears the
// tag when the selected bit is set.
// Assumes: cap_base_i and filt_en_i are valid with ld_valid_i; loads offered
// while busy are dropped.
module cap_revoke_filter #(
    parameter int          DATA_W     = 33,
    parameter int          ADDR_W     = 32,
    parameter int          SMAP_W     = 32,
    parameter logic [31:0] HEAP_BASE  = 32'h8000_0000,
    parameter int          SMAP_WORDS = 1024,
    parameter logic [31:0] SMAP_BASE  = 32'h4000_0000,
    parameter logic [31:0] SMAP_TOP   = SMAP_BASE + 32'(4*SMAP_WORDS) - 32'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic [ADDR_W-1:0] cap_base_i,
    input  logic              filt_en_i,
    output logic              busy_o,
    output logic              smap_req_o,
    output logic [ADDR_W-1:0] smap_addr_o,
    input  logic              smap_rsp_valid_i,
    input  logic [SMAP_W-1:0] smap_rsp_data_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o
);
    localparam int TAG   = DATA_W - 1;
    localparam int SEL_W = $clog2(SMAP_W);

    logic              qualify, accept, need_lookup, idle, capture, picked;
    logic [ADDR_W-1:0] word_addr;
    logic [4:0]        bit_sel;
    logic [DATA_W-1:0] cap_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SEL_W-1:0]  sel_q;

    revf_addr_calc #(
        .ADDR_W(ADDR_W), .HEAP_BASE(HEAP_BASE), .SMAP_WORDS(SMAP_WORDS),
        .SMAP_BASE(SMAP_BASE), .SMAP_TOP(SMAP_TOP)
    ) u_addr (
        .base_i(cap_base_i), .qualify_o(qualify),
        .word_addr_o(word_addr), .bit_sel_o(bit_sel)
    );

    // Acceptance and lookup decision
    always_comb begin
        accept      = ld_valid_i && idle;
        need_lookup = filt_en_i && ld_data_i[TAG] && qualify;
    end

    revf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .need_lookup_i(need_lookup),
        .rsp_valid_i(smap_rsp_valid_i), .idle_o(idle), .req_o(smap_req_o),
        .capture_o(capture), .done_o(res_valid_o)
    );

    revf_bit_pick #(.WORD_W(SMAP_W)) u_pick (
        .word_i(smap_rsp_data_i), .sel_i(sel_q), .bit_o(picked)
    );

    // Hold the word, address and select; clear the tag on a revoked bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            addr_q <= '0;
            sel_q  <= '0;
        end else if (accept) begin
            cap_q  <= ld_data_i;
            addr_q <= word_addr;
            sel_q  <= SEL_W'(bit_sel);
        end else if (capture && picked) begin
            cap_q[TAG] <= 1'b0;
        end
    end

    // Output drive
    always_comb begin
        busy_o      = !idle;
        smap_addr_o = addr_q;
        res_data_o  = cap_q;
    end

    a_r4_off_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && !busy_o && !filt_en_i) |=> !smap_req_o && res_valid_o);
    a_r8_untagged_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && !busy_o && !ld_data_i[TAG]) |=> res_valid_o && !res_data_o[TAG]);
    a_r7_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        smap_req_o |-> (smap_addr_o >= ADDR_W'(SMAP_BASE)) && (smap_addr_o <= ADDR_W'(SMAP_TOP)));
    a_r9_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (smap_req_o || res_valid_o) |-> busy_o);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !smap_rsp_valid_i) |=> $stable(res_data_o));
    a_r2_revoke: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !smap_req_o && !res_valid_o && smap_rsp_valid_i &&
         smap_rsp_data_i[sel_q]) |=> res_valid_o && !res_data_o[TAG]);
endmodule

// File: tb/sim_cap_revoke_filter.sv
module sim_cap_revoke_filter;
    localparam logic [31:0] HB  = 32'h8000_0000;
    localparam logic [31:0] SB  = 32'h4000_0000;
    localparam logic [31:0] TOP = 32'h4000_0F9C; // last usable word 999
    localparam int          NW  = 1024;

    logic        clk = 0, rst_n = 0;
    logic        ld_valid = 0, filt_en = 0, rsp_valid = 0;
    logic [32:0] ld_data = '0;
    logic [31:0] base = '0, rsp_data = '0, smap_addr;
    logic        busy, req, res_valid;
    logic [32:0] res_data;
    logic [31:0] shadow [NW];
    int          total = 0, bad = 0, cyc = 0;
    bit          ended = 0;

    always #5 clk = ~clk;

    cap_revoke_filter #(.HEAP_BASE(HB), .SMAP_WORDS(NW), .SMAP_BASE(SB), .SMAP_TOP(TOP)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_valid), .ld_data_i(ld_data),
        .cap_base_i(base), .filt_en_i(filt_en), .busy_o(busy), .smap_req_o(req),
        .smap_addr_o(smap_addr), .smap_rsp_valid_i(rsp_valid), .smap_rsp_data_i(rsp_data),
        .res_valid_o(res_valid), .res_data_o(res_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=<50000", cyc);
            finish_run();
        end
    end

    // One load, checked on every cycle against a behavioural model
    task automatic run(input logic [31:0] b, input bit tag, input bit en,
                       input logic [31:0] pay, input int lat, input bit poke, input string rq);
        longint off = longint'(b) - longint'(HB);
        bit     inheap = (off >= 0) && (off < longint'(NW) * 256);
        longint waddr = longint'(SB) + (off >>> 8) * 4;
        int     bsel = int'((off >>> 3) & 31);
        bit     look = en && tag && inheap && (waddr <= longint'(TOP));
        bit     exp_tag = tag;
        @(negedge clk);
        ld_valid = 1; ld_data = {tag, pay}; base = b; filt_en = en;
        @(negedge clk);
        ld_valid = 0; ld_data = '0; base = '0;
        if (look) begin
            chk(req && busy && !res_valid, {rq, " R9 req"}, {req, busy, res_valid}, 3'b110);
            chk(smap_addr == waddr[31:0], {rq, " R6 addr"}, smap_addr, waddr);
            exp_tag = !shadow[(smap_addr - SB) >> 2][bsel];
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                if (poke && i == 1) begin
                    ld_valid = 1; ld_data = 33'h0_DEAD_BEEF; base = HB;
                end
                chk(busy && !req && !res_valid, {rq, " R9 wait"}, {busy, req, res_valid}, 3'b100);
            end
            @(negedge clk);
            ld_valid = 0;
            if (lat == 1)
                chk(busy && !req && !res_valid, {rq, " R9 wait"}, {busy, req, res_valid}, 3'b100);
            rsp_valid = 1; rsp_data = shadow[(smap_addr - SB) >> 2];
            @(negedge clk);
            rsp_valid = 0; rsp_data = '0;
        end else begin
            chk(!req, {rq, " no request"}, req, 0);
        end
        chk(res_valid && busy, {rq, " R9 result strobe"}, {res_valid, busy}, 2'b11);
        chk(res_data[32] == exp_tag, {rq, exp_tag ? " R3 tag kept" : " R2 tag cleared"}, res_data[32], exp_tag);
        chk(res_data[31:0] == pay, {rq, " R3 payload"}, res_data[31:0], pay);
        @(negedge clk);
        chk(!res_valid && !busy && !req, {rq, " R9 back idle"}, {res_valid, busy, req}, 0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) shadow[i] = '0;
        shadow[0]   = 32'h8000_0001;   // bits 0 and 31 revoked
        shadow[1]   = 32'h0000_0002;   // bit 33 revoked, bit 32 clear
        shadow[999] = 32'h8000_0000;
        shadow[1000]= 32'hFFFF_FFFF;   // beyond top: never read
        repeat (3) @(negedge clk);
        chk(!busy && !req && !res_valid, "R1 reset", {busy, req, res_valid}, 0);
        rst_n = 1;
        run(HB,             1, 1, 32'h1111_0000, 1, 0, "R2 bit0");
        run(HB + 32'h0F8,   1, 1, 32'h2222_0000, 3, 0, "R6 bit31");
        run(HB + 32'h100,   1, 1, 32'h3333_0000, 2, 0, "R6 bit32");
        run(HB + 32'h108,   1, 1, 32'h4444_0000, 1, 0, "R6 bit33");
        run(HB - 32'd8,     1, 1, 32'h5555_0000, 1, 0, "R5 below heap");
        run(HB + 32'h4_0000,1, 1, 32'h6666_0000, 1, 0, "R5 heap end");
        run(HB,             1, 0, 32'h7777_0000, 1, 0, "R4 disabled");
        run(HB,             0, 1, 32'h8888_0000, 1, 0, "R8 untagged");
        run(HB + 32'h3_E800,1, 1, 32'h9999_0000, 1, 0, "R7 past top");
        run(HB + 32'h3_E7F8,1, 1, 32'hAAAA_0000, 2, 0, "R7 last word");
        // R10: stray response while idle, then a load offered while busy
        @(negedge clk);
        rsp_valid = 1; rsp_data = 32'hFFFF_FFFF;
        @(negedge clk);
        rsp_valid = 0; rsp_data = '0;
        chk(!busy && !res_valid, "R10 stray response", {busy, res_valid}, 0);
        run(HB + 32'h100,   1, 1, 32'hBBBB_0000, 3, 1, "R10 busy load");
        finish_run();
    end
endmodule